// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block sits between a processor request port and a main-memory port. The processor presents a 24-bit byte address with a read or write of one 16-bit word. The controller looks the address up in two ways of a set-indexed tag store. When both tags miss, it refills the 4-byte line from memory before it completes the request. Writes stay in the cache and mark the line modified. A modified line goes back to memory only when it is chosen for eviction.

Each set keeps one bit naming its most recently referenced way, and the victim is the other way. An empty way is always filled before any valid line is evicted. A write miss allocates: the line is fetched, and then the write data is merged into it. The processor sees a single stall signal. It holds its request steady while the stall is high and takes the result in the first cycle the stall is low. The memory side uses a request/acknowledge pair and moves whole lines.

Top module: `two_way_wb_cache`

## Requirements
- R1: The address is split from the top down into a tag, a set index of SET_W bits and a 2-bit offset. The memory line address is cpu_addr[23:2]. Address bit 1 selects the half of the 32-bit line: 0 selects line bits [15:0] and 1 selects bits [31:16]. Address bit 0 is ignored. At most one way matches in a set.
- R2: A read or write that hits completes in the cycle it is presented. cpu_stall stays low and mem_req is not asserted. On a read, cpu_rdata carries the selected word.
- R3: A read miss raises cpu_stall and issues exactly one memory read (mem_we=0) of the requested line. cpu_stall falls in the cycle after that read is acknowledged, with the word taken from the fetched line.
- R4: A write hit changes only the cached line. No memory transaction occurs, and a later read returns the new word.
- R5: A write miss fetches the line and merges the write word into it. The other half of the line keeps its memory value.
- R6: Each reference marks its way as most recent in the set. When both ways are valid, a miss evicts the way that was not referenced last.
- R7: A miss fills an invalid way of the set before it evicts any valid line.
- R8: If the victim line is modified, one memory write (mem_we=1) of that line's address and data comes before the refill read. If the victim is clean or empty, no write occurs.
- R9: Once mem_req is raised, it stays high with mem_we, mem_addr and mem_wdata unchanged until the cycle mem_ack is seen.
- R10: After reset every line is invalid, cpu_stall is low while no request is present, and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 16 | Write word |
| cpu_rdata | output | 16 | Read word, valid when cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | Request not yet complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-2 | Line address |
| mem_wdata | output | 32 | Line being written back |
| mem_rdata | input | 32 | Fetched line, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current transaction |

## Verification
The embedded properties check the following on every cycle: a completed request never overlaps memory traffic, the memory request stays stable until it is acknowledged, the state machine enters write-back only for a valid modified victim, at most one way matches, a refill is followed by completion, and each reference is recorded as most recent. Some behaviours only the bench scenarios can show: which line is evicted, whether the written-back data is the right data, whether merged halves survive, and whether read data stays coherent across many evictions. The bench shows these by comparing every access against a behavioural model of the per-set recency order and the memory contents.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int WORD_W = 16;
  localparam int LINE_W = 2 * WORD_W;
  localparam int OFF_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } cwb_state_e;
endpackage

// File: rtl/cwb_way_store.sv
module cwb_way_store #(
  parameter int SET_W  = 6,
  parameter int TAG_W  = 16,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q, valid_d;
  logic [SETS-1:0]   dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (wr_en) begin
      valid_d[wr_set] = 1'b1;
      dirty_d[wr_set] = wr_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      line_q[wr_set] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_line  = line_q[rd_set];
endmodule

// File: rtl/cwb_use_bits.sv
module cwb_use_bits #(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_mru
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] mru_q, mru_d;

  always_comb begin
    mru_d = mru_q;
    if (touch_en) mru_d[touch_set] = touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mru_q <= '0;
    else        mru_q <= mru_d;
  end

  assign rd_mru = mru_q[rd_set];

  // R6: a reference is recorded as the most recent way of its set
  a_r6_touch_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> mru_q[$past(touch_set)] == $past(touch_way));
endmodule

// File: rtl/two_way_wb_cache.sv
module two_way_wb_cache #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [15:0]               cpu_wdata,
  output logic [15:0]               cpu_rdata,
  output logic                      cpu_stall,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-3:0]         mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic [31:0]               mem_rdata,
  input  logic                      mem_ack
);
  import cwb_pkg::*;

  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int WAYS  = 2;

  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic              word_hi;

  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_set = cpu_addr[OFF_W +: SET_W];
  assign word_hi = cpu_addr[1];

  logic [WAYS-1:0]   w_valid, w_dirty, way_wr, hit_vec;
  logic [TAG_W-1:0]  w_tag  [WAYS];
  logic [LINE_W-1:0] w_line [WAYS];
  logic [TAG_W-1:0]  wr_tag_c;
  logic [LINE_W-1:0] wr_line_c;
  logic              wr_dirty_c;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cwb_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (req_set),
      .rd_valid (w_valid[w]),
      .rd_dirty (w_dirty[w]),
      .rd_tag   (w_tag[w]),
      .rd_line  (w_line[w]),
      .wr_en    (way_wr[w]),
      .wr_set   (req_set),
      .wr_tag   (wr_tag_c),
      .wr_line  (wr_line_c),
      .wr_dirty (wr_dirty_c)
    );
    assign hit_vec[w] = w_valid[w] && (w_tag[w] == req_tag);
  end

  logic hit_way, any_hit, mru, touch, victim_c;
  assign any_hit = |hit_vec;
  assign hit_way = hit_vec[1];

  cwb_use_bits #(.SET_W(SET_W)) u_use (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch),
    .touch_set (req_set),
    .touch_way (hit_way),
    .rd_set    (req_set),
    .rd_mru    (mru)
  );

  // empty way first, otherwise the way not referenced last
  assign victim_c = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : ~mru);

  function automatic logic [LINE_W-1:0] merge_word(
    input logic [LINE_W-1:0] line, input logic hi, input logic [WORD_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = line;
    if (hi) r[LINE_W-1:WORD_W] = d;
    else    r[WORD_W-1:0]      = d;
    return r;
  endfunction

  cwb_state_e state_q, state_d;
  logic       vic_q, vic_d;

  always_comb begin
    state_d    = state_q;
    vic_d      = vic_q;
    way_wr     = '0;
    touch      = 1'b0;
    wr_tag_c   = req_tag;
    wr_line_c  = merge_word(w_line[hit_way], word_hi, cpu_wdata);
    wr_dirty_c = 1'b1;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = {req_tag, req_set};
    mem_wdata  = w_line[vic_q];
    case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (any_hit) begin
            touch           = 1'b1;
            way_wr[hit_way] = cpu_we;
          end else begin
            vic_d   = victim_c;
            state_d = (w_valid[victim_c] && w_dirty[victim_c]) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {w_tag[vic_q], req_set};
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          way_wr[vic_q] = 1'b1;
          wr_line_c     = cpu_we ? merge_word(mem_rdata, word_hi, cpu_wdata) : mem_rdata;
          wr_dirty_c    = cpu_we;
          state_d       = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vic_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vic_q   <= vic_d;
    end
  end

  assign cpu_stall = cpu_req && !(state_q == ST_IDLE && any_hit);
  assign cpu_rdata = word_hi ? w_line[hit_way][LINE_W-1:WORD_W] : w_line[hit_way][WORD_W-1:0];

  // R1: tags within a set never match twice
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> $onehot0(hit_vec));
  // R2: a completing request causes no memory traffic
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> !mem_req);
  // R3: a refill acknowledged lets the held request complete next cycle
  a_r3_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (!cpu_req || !cpu_stall));
  // R8: write-back is entered only for a valid modified victim
  a_r8_evict_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT) |-> (w_valid[vic_q] && w_dirty[vic_q]));
  // R9: request held steady until acknowledged
  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: tb/test_two_way_wb_cache.sv
module test_two_way_wb_cache;
  localparam int SW   = 2;
  localparam int SETS = 1 << SW;
  localparam int LAT  = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [23:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        cpu_stall, mem_req, mem_we, mem_ack;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  two_way_wb_cache #(.ADDR_W(24), .SET_W(SW)) i_two_way_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack));

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [31:0] mm    [logic [21:0]];
  logic [31:0] truth [logic [21:0]];
  bit          dirty_m [logic [21:0]];
  logic [21:0] lru_q [SETS][$];

  function automatic logic [31:0] init_line(logic [21:0] l);
    return {l[15:0] ^ 16'h5A3C, ~l[15:0]};
  endfunction
  function automatic logic [31:0] mm_get(logic [21:0] l);
    return mm.exists(l) ? mm[l] : init_line(l);
  endfunction
  function automatic logic [31:0] truth_get(logic [21:0] l);
    return truth.exists(l) ? truth[l] : init_line(l);
  endfunction
  function automatic logic [23:0] mk(int tg, int st, int wd, int b0);
    logic [23:0] a;
    a = {tg[19:0], st[1:0], wd[0], b0[0]};
    return a;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic access(input bit we, input logic [23:0] a, input logic [15:0] wd, input string rq);
    logic [21:0] ln, vic, rd_a, wr_a, pa;
    logic [31:0] wr_d, tl, pd;
    logic [15:0] exp_word;
    int s, pos, n_rd, n_wr, stall_cyc, waitc, guard;
    bit exp_hit, exp_wb, wr_first, pv, pw;
    ln = a[23:2]; s = int'(ln) % SETS; pos = -1; exp_wb = 0; vic = '0;
    for (int i = 0; i < lru_q[s].size(); i++) if (lru_q[s][i] == ln) pos = i;
    exp_hit = (pos >= 0);
    if (!exp_hit && lru_q[s].size() == 2) begin
      vic = lru_q[s][1];
      exp_wb = dirty_m.exists(vic) && dirty_m[vic];
    end
    if (exp_hit) lru_q[s].delete(pos);
    else if (lru_q[s].size() == 2) begin lru_q[s].delete(1); dirty_m[vic] = 0; end
    lru_q[s].push_front(ln);
    tl = truth_get(ln);
    exp_word = a[1] ? tl[31:16] : tl[15:0];
    if (we) begin
      if (a[1]) tl[31:16] = wd; else tl[15:0] = wd;
      truth[ln] = tl;
      dirty_m[ln] = 1;
    end
    n_rd = 0; n_wr = 0; stall_cyc = 0; waitc = 0; wr_first = 1; guard = 0;
    rd_a = '0; wr_a = '0; wr_d = '0; pv = 0; pw = 0; pa = '0; pd = '0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      mem_ack = 0;
      #1;
      if (pv) check(mem_req && mem_we == pw && mem_addr == pa && (!pw || mem_wdata == pd),
                    "R9 request held until ack", {10'd0, mem_addr}, {10'd0, pa});
      pv = 0;
      if (!cpu_stall) break;
      stall_cyc++;
      if (mem_req) begin
        waitc++;
        if (waitc >= LAT) begin
          waitc = 0;
          if (mem_we) begin
            n_wr++; wr_a = mem_addr; wr_d = mem_wdata; mm[mem_addr] = mem_wdata;
            if (n_rd > 0) wr_first = 0;
          end else begin
            n_rd++; rd_a = mem_addr; mem_rdata = mm_get(mem_addr);
          end
          mem_ack = 1;
        end else begin
          pv = 1; pw = mem_we; pa = mem_addr; pd = mem_wdata;
        end
      end
      guard++;
      if (guard > 200) break;
      @(negedge clk);
    end
    if (exp_hit) check(stall_cyc == 0, {rq, " R2 hit completes at once"}, stall_cyc, 0);
    else         check(stall_cyc > 0, {rq, " R3 miss stalls"}, stall_cyc, 1);
    check(n_rd == (exp_hit ? 0 : 1), {rq, " R3 one line fetch per miss"}, n_rd, exp_hit ? 0 : 1);
    if (!exp_hit) check(rd_a == ln, {rq, " R1 fetch line address"}, {10'd0, rd_a}, {10'd0, ln});
    check(n_wr == int'(exp_wb), {rq, " R8 write-back count"}, n_wr, exp_wb);
    if (exp_wb) begin
      check(wr_a == vic, {rq, " R6 evicted line address"}, {10'd0, wr_a}, {10'd0, vic});
      check(wr_d == truth_get(vic), {rq, " R8 written-back data"}, wr_d, truth_get(vic));
      check(wr_first, {rq, " R8 write-back before fetch"}, wr_first, 1);
    end
    if (!we) check(cpu_rdata == exp_word, {rq, " R1 read word"}, cpu_rdata, exp_word);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL R3 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int lcg;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    mem_ack = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(!cpu_stall, "R10 stall low after reset", cpu_stall, 0);
    check(!mem_req, "R10 no memory request after reset", mem_req, 0);

    access(0, mk(1, 0, 0, 0), 16'h0, "R10 R7 first read misses");
    access(0, mk(1, 0, 1, 0), 16'h0, "R2 read hit upper word");
    access(0, mk(1, 0, 1, 1), 16'h0, "R1 address bit0 ignored");
    access(1, mk(1, 0, 0, 0), 16'hBEEF, "R4 write hit");
    access(0, mk(1, 0, 0, 0), 16'h0, "R4 read back written word");
    access(1, mk(2, 0, 1, 0), 16'hCAFE, "R5 R7 write miss allocates");
    access(0, mk(2, 0, 0, 0), 16'h0, "R5 other half preserved");
    access(0, mk(2, 0, 1, 0), 16'h0, "R5 merged half");
    access(0, mk(1, 0, 1, 0), 16'h0, "R6 touch first line");
    access(0, mk(3, 0, 0, 0), 16'h0, "R6 R8 dirty victim written back");
    access(0, mk(2, 0, 1, 0), 16'h0, "R8 evicted data returns");
    access(0, mk(4, 1, 0, 0), 16'h0, "R7 clean fill");
    access(0, mk(5, 1, 0, 0), 16'h0, "R7 second way");
    access(0, mk(6, 1, 1, 0), 16'h0, "R8 clean victim no write");

    lcg = 12345;
    for (int k = 0; k < 300; k++) begin
      lcg = lcg * 1103515245 + 12345;
      access(lcg[20], mk(int'(lcg[19:18]), int'(lcg[17:16]), int'(lcg[15]), 0),
             lcg[31:16], "R6 mixed traffic");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule